// File: doc/BRIEF.md
# Stacked Register Frame Renamer

This block turns a logical general-register number into an index into a physical register file. The file has 128 entries: 32 static ones and a 96-entry circular pool for procedure frames. Logical registers below 32 are the same in every procedure. Logical registers from 32 upward belong to the current procedure's frame. A frame is a window into the circular pool. It starts at a frame base and is split into a local area followed by an output area.

A call slides the window so that the callee's frame starts where the caller's output area starts. The callee begins with no local registers, and the shared registers keep their physical location. A return brings back the caller's frame marker from an internal marker stack. An allocate command resizes the current frame and sets the size of a rotating region that starts at logical register 32. Inside that region a rotating base is added to the offset, modulo the region size. Each loop-rotate event shifts the mapping by one register toward higher numbers, so the value seen at logical register L is seen at L+1 afterwards.

The rename path is combinational. Frame marker updates take effect on the clock edge that samples the event. Spilling to memory is not done here: the block only reports when the current frame straddles the end of the physical pool.

Top module: `stack_renamer`

## Requirements
- R1: A logical register below 32 maps to the same index, with `oof_o` low, whatever the frame state.
- R2: For logical register L ≥ 32 with offset d = L−32, where frame size sof = local + output: if d ≥ sof then `oof_o` is 1 and `preg_o` is 0. Otherwise, when d is not below the rotating size, `preg_o` = 32 + ((base + d) mod 96).
- R3: An accepted call pushes the current marker. It sets the new base to (base + local) mod 96, the local size to 0 and the rotating size and rotating base to 0, and keeps the output size. Logical register 32 of the callee therefore maps to the caller's first output register.
- R4: A return with a non-empty marker stack restores the caller's marker in full. A return with an empty stack leaves the marker unchanged and raises `err_o`.
- R5: An allocate command is accepted only if local + output ≤ 96, the rotating size is a multiple of 8 (its 3 low bits are zero) and the rotating size ≤ local + output. It then sets the three sizes and clears the rotating base. Otherwise the marker is unchanged and `err_o` is raised.
- R6: For d below the rotating size r, the offset used is (d + rrb) mod r before the base is added.
- R7: A loop-rotate event with r ≠ 0 sets rrb to (rrb − 1) mod r, so the index seen at L is then seen at L+1, and the top of the region wraps to logical register 32. With r = 0 the marker does not change.
- R8: The marker stack holds 8 entries. A call when it is full leaves the marker unchanged and raises `err_o`.
- R9: `wrap_o` is high exactly when base + sof > 96.
- R10: When several events arrive in one cycle, only the first of call, return, allocate and rotate, in that order, is acted on.
- R11: After reset the base and all sizes are 0, the marker stack is empty and `err_o` is low. A cycle with no event leaves the marker unchanged, and `err_o` is high only in the cycle after a rejected event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lreg_i | input | 7 | Logical register number to translate |
| call_i | input | 1 | Procedure call event |
| ret_i | input | 1 | Procedure return event |
| alloc_i | input | 1 | Frame allocate command |
| alloc_loc_i | input | 7 | Requested local area size |
| alloc_out_i | input | 7 | Requested output area size |
| alloc_rot_i | input | 7 | Requested rotating region size |
| rotate_i | input | 1 | Loop-rotate event |
| preg_o | output | 7 | Physical register index |
| oof_o | output | 1 | Logical register lies beyond the current frame |
| wrap_o | output | 1 | Current frame straddles the end of the physical pool |
| err_o | output | 1 | Previous cycle's event was rejected |

## Verification
The bench aims at these corners:
- The rotate direction. A design that increments the rotating base would move values toward lower numbers, and logical register L+1 would no longer show the index L showed before.
- Frames that cross physical index 127. A base sum that is not reduced modulo 96 would produce indices past the pool, or a wrong `wrap_o`.
- The depth limits of the marker stack at both ends. An off-by-one would accept a ninth call or fail to flag a return with nothing to pop.
- Rotating sizes that break the multiple-of-8 rule or exceed the frame, which must leave the old mapping intact.
- Simultaneous events, where a wrong priority shows up as a callee frame that keeps local registers or a rotated base.

// File: rtl/sren_pkg.sv
`timescale 1ns/1ps
package sren_pkg;

    localparam int unsigned N_STATIC  = 32;
    localparam int unsigned N_STACKED = 96;
    localparam int unsigned LR_W      = 7;
    localparam int unsigned SZ_W      = 7;
    localparam int unsigned ROT_GRAN  = 8;
    localparam int unsigned ROT_LSB   = $clog2(ROT_GRAN);

    typedef logic [LR_W-1:0] lreg_t;
    typedef logic [SZ_W-1:0] fsz_t;

    typedef struct packed {
        fsz_t base;
        fsz_t loc;
        fsz_t outs;
        fsz_t rot;
        fsz_t rrb;
    } fmark_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_CALL,
        EV_RET,
        EV_ALLOC,
        EV_ROT
    } ev_e;

    // (a + b) mod m, valid for a < m and b <= m
    function automatic fsz_t mod_add(fsz_t a, fsz_t b, fsz_t m);
        logic [SZ_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, m}) begin
            s = s - {1'b0, m};
        end
        return s[SZ_W-1:0];
    endfunction

    function automatic logic [SZ_W:0] frame_size(fsz_t l, fsz_t o);
        return {1'b0, l} + {1'b0, o};
    endfunction

    function automatic logic alloc_ok(fsz_t l, fsz_t o, fsz_t r);
        logic [SZ_W:0] s;
        s = frame_size(l, o);
        return (s <= (SZ_W+1)'(N_STACKED)) &&
               (r[ROT_LSB-1:0] == '0) &&
               ({1'b0, r} <= s);
    endfunction

endpackage

// File: rtl/ren_mstack.sv
`timescale 1ns/1ps
module ren_mstack
    import sren_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  logic   pop,
    input  fmark_t din,
    output fmark_t top,
    output logic   empty,
    output logic   full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    fmark_t           mem [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] top_idx;
    logic [PTR_W-1:0] wr_idx;

    assign top_idx = PTR_W'(cnt - CNT_W'(1));
    assign wr_idx  = PTR_W'(cnt);
    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign top     = empty ? '0 : mem[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push && !full) begin
            mem[wr_idx] <= din;
            cnt         <= cnt + CNT_W'(1);
        end else if (pop && !empty) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/ren_frame_ctrl.sv
`timescale 1ns/1ps
module ren_frame_ctrl
    import sren_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   call_i,
    input  logic   ret_i,
    input  logic   alloc_i,
    input  logic   rotate_i,
    input  fsz_t   alloc_loc_i,
    input  fsz_t   alloc_out_i,
    input  fsz_t   alloc_rot_i,
    input  fmark_t stk_top,
    input  logic   stk_empty,
    input  logic   stk_full,
    output fmark_t cur,
    output logic   push,
    output logic   pop,
    output logic   err_q
);
    ev_e    ev;
    fmark_t nxt;
    logic   bad;

    // fixed priority among simultaneous events
    always_comb begin
        if (call_i)        ev = EV_CALL;
        else if (ret_i)    ev = EV_RET;
        else if (alloc_i)  ev = EV_ALLOC;
        else if (rotate_i) ev = EV_ROT;
        else               ev = EV_NONE;
    end

    always_comb begin
        nxt  = cur;
        push = 1'b0;
        pop  = 1'b0;
        bad  = 1'b0;
        case (ev)
            EV_CALL: begin
                if (stk_full) begin
                    bad = 1'b1;
                end else begin
                    push     = 1'b1;
                    nxt.base = mod_add(cur.base, cur.loc, SZ_W'(N_STACKED));
                    nxt.loc  = '0;
                    nxt.rot  = '0;
                    nxt.rrb  = '0;
                end
            end
            EV_RET: begin
                if (stk_empty) begin
                    bad = 1'b1;
                end else begin
                    pop = 1'b1;
                    nxt = stk_top;
                end
            end
            EV_ALLOC: begin
                if (!alloc_ok(alloc_loc_i, alloc_out_i, alloc_rot_i)) begin
                    bad = 1'b1;
                end else begin
                    nxt.loc  = alloc_loc_i;
                    nxt.outs = alloc_out_i;
                    nxt.rot  = alloc_rot_i;
                    nxt.rrb  = '0;
                end
            end
            EV_ROT: begin
                if (cur.rot != '0) begin
                    nxt.rrb = (cur.rrb == '0) ? (cur.rot - SZ_W'(1))
                                              : (cur.rrb - SZ_W'(1));
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            err_q <= 1'b0;
        end else begin
            cur   <= nxt;
            err_q <= bad;
        end
    end

endmodule

// File: rtl/ren_xlate.sv
`timescale 1ns/1ps
module ren_xlate
    import sren_pkg::*;
(
    input  fmark_t cur,
    input  lreg_t  lreg,
    output lreg_t  preg,
    output logic   oof,
    output logic   wraps
);
    logic [SZ_W:0] sof;
    fsz_t          off;
    fsz_t          roff;
    fsz_t          phys;

    assign sof   = frame_size(cur.loc, cur.outs);
    assign off   = fsz_t'(lreg - LR_W'(N_STATIC));
    assign wraps = ({1'b0, cur.base} + sof) > (SZ_W+1)'(N_STACKED);

    always_comb begin
        roff = (off < cur.rot) ? mod_add(off, cur.rrb, cur.rot) : off;
        phys = mod_add(cur.base, roff, SZ_W'(N_STACKED));
        if (lreg < LR_W'(N_STATIC)) begin
            preg = lreg;
            oof  = 1'b0;
        end else if ({1'b0, off} >= sof) begin
            preg = '0;
            oof  = 1'b1;
        end else begin
            preg = LR_W'(N_STATIC) + LR_W'(phys);
            oof  = 1'b0;
        end
    end

endmodule

// File: rtl/stack_renamer.sv
`timescale 1ns/1ps
module stack_renamer
    import sren_pkg::*;
#(
    parameter int unsigned MSTK_DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [6:0] lreg_i,
    input  logic       call_i,
    input  logic       ret_i,
    input  logic       alloc_i,
    input  logic [6:0] alloc_loc_i,
    input  logic [6:0] alloc_out_i,
    input  logic [6:0] alloc_rot_i,
    input  logic       rotate_i,
    output logic [6:0] preg_o,
    output logic       oof_o,
    output logic       wrap_o,
    output logic       err_o
);
    fmark_t cur_m;
    fmark_t stk_top;
    logic   stk_empty;
    logic   stk_full;
    logic   push;
    logic   pop;

    ren_mstack #(.DEPTH(MSTK_DEPTH)) u_mstack (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .din   (cur_m),
        .top   (stk_top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    ren_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .call_i      (call_i),
        .ret_i       (ret_i),
        .alloc_i     (alloc_i),
        .rotate_i    (rotate_i),
        .alloc_loc_i (alloc_loc_i),
        .alloc_out_i (alloc_out_i),
        .alloc_rot_i (alloc_rot_i),
        .stk_top     (stk_top),
        .stk_empty   (stk_empty),
        .stk_full    (stk_full),
        .cur         (cur_m),
        .push        (push),
        .pop         (pop),
        .err_q       (err_o)
    );

    ren_xlate u_xlate (
        .cur   (cur_m),
        .lreg  (lreg_i),
        .preg  (preg_o),
        .oof   (oof_o),
        .wraps (wrap_o)
    );

endmodule

// File: rtl/stack_renamer_chk.sv
`timescale 1ns/1ps
module stack_renamer_chk
    import sren_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [6:0] lreg_i,
    input logic       call_i,
    input logic       ret_i,
    input logic       alloc_i,
    input logic       rotate_i,
    input logic [6:0] preg_o,
    input logic       oof_o,
    input logic       err_o,
    input fmark_t     cur_m,
    input logic       stk_empty,
    input logic       stk_full
);

    p_static_ident_r1: assert property (@(posedge clk) disable iff (rst)
        (lreg_i < 7'd32) |-> (preg_o == lreg_i && !oof_o));

    p_oof_zero_r2: assert property (@(posedge clk) disable iff (rst)
        oof_o |-> (preg_o == 7'd0 && lreg_i >= 7'd32));

    p_call_slide_r3: assert property (@(posedge clk) disable iff (rst)
        (call_i && !stk_full) |=> (cur_m.loc == '0 && cur_m.outs == $past(cur_m.outs)));

    p_ret_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i && stk_empty) |=> (err_o && $stable(cur_m)));

    p_rot_legal_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_m.rot[2:0] == 3'b000) &&
        ({1'b0, cur_m.rot} <= ({1'b0, cur_m.loc} + {1'b0, cur_m.outs})));

    p_rrb_range_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_m.rot == '0) ? (cur_m.rrb == '0) : (cur_m.rrb < cur_m.rot));

    p_rot_none_r7: assert property (@(posedge clk) disable iff (rst)
        (rotate_i && !call_i && !ret_i && !alloc_i && cur_m.rot == '0) |=> $stable(cur_m));

    p_full_reject_r8: assert property (@(posedge clk) disable iff (rst)
        (call_i && stk_full) |=> (err_o && $stable(cur_m)));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!call_i && !ret_i && !alloc_i && !rotate_i) |=> ($stable(cur_m) && !err_o));

endmodule

bind stack_renamer stack_renamer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lreg_i    (lreg_i),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .alloc_i   (alloc_i),
    .rotate_i  (rotate_i),
    .preg_o    (preg_o),
    .oof_o     (oof_o),
    .err_o     (err_o),
    .cur_m     (cur_m),
    .stk_empty (stk_empty),
    .stk_full  (stk_full)
);

// File: tb/stack_renamer_bench.sv
`timescale 1ns/1ps
module stack_renamer_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] lreg_i = '0;
    logic       call_i = 1'b0, ret_i = 1'b0, alloc_i = 1'b0, rotate_i = 1'b0;
    logic [6:0] alloc_loc_i = '0, alloc_out_i = '0, alloc_rot_i = '0;
    logic [6:0] preg_o;
    logic       oof_o, wrap_o, err_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference frame model
    int m_base, m_loc, m_out, m_rot, m_rrb;
    int s_base[8], s_loc[8], s_out[8], s_rot[8], s_rrb[8];
    int sp;
    int exp_err;

    always #2 clk = ~clk;

    stack_renamer u_stack_renamer (
        .clk(clk), .rst(rst), .lreg_i(lreg_i),
        .call_i(call_i), .ret_i(ret_i), .alloc_i(alloc_i),
        .alloc_loc_i(alloc_loc_i), .alloc_out_i(alloc_out_i), .alloc_rot_i(alloc_rot_i),
        .rotate_i(rotate_i), .preg_o(preg_o), .oof_o(oof_o), .wrap_o(wrap_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_map(int l);
        int off, r;
        if (l < 32) return l;
        off = l - 32;
        if (off >= m_loc + m_out) return -1;
        r = off;
        if (off < m_rot) r = (off + m_rrb) % m_rot;
        return 32 + ((m_base + r) % 96);
    endfunction

    function automatic int model_ev(bit c, bit r, bit a, int lo, int ou, int ro, bit rt);
        if (c) begin
            if (sp == 8) return 1;
            s_base[sp] = m_base; s_loc[sp] = m_loc; s_out[sp] = m_out;
            s_rot[sp] = m_rot; s_rrb[sp] = m_rrb; sp++;
            m_base = (m_base + m_loc) % 96; m_loc = 0; m_rot = 0; m_rrb = 0;
            return 0;
        end
        if (r) begin
            if (sp == 0) return 1;
            sp--;
            m_base = s_base[sp]; m_loc = s_loc[sp]; m_out = s_out[sp];
            m_rot = s_rot[sp]; m_rrb = s_rrb[sp];
            return 0;
        end
        if (a) begin
            if (lo + ou > 96 || ro % 8 != 0 || ro > lo + ou) return 1;
            m_loc = lo; m_out = ou; m_rot = ro; m_rrb = 0;
            return 0;
        end
        if (rt && m_rot != 0) m_rrb = (m_rrb == 0) ? m_rot - 1 : m_rrb - 1;
        return 0;
    endfunction

    task automatic read_map(input int l, output int p, output bit o);
        lreg_i = 7'(l);
        #1;
        p = preg_o;
        o = oof_o;
    endtask

    task automatic check_map(input int l, input string req);
        int p, e;
        bit o;
        read_map(l, p, o);
        e = exp_map(l);
        if (e < 0) chk(o == 1'b1 && p == 0, req, o ? -1 : p, -1);
        else       chk(o == 1'b0 && p == e, req, o ? -1 : p, e);
    endtask

    // apply one event cycle, then check error and wrap flags
    task automatic ev(input bit c, input bit r, input bit a, input int lo, input int ou,
                      input int ro, input bit rt, input string req);
        @(negedge clk);
        call_i = c; ret_i = r; alloc_i = a; rotate_i = rt;
        alloc_loc_i = 7'(lo); alloc_out_i = 7'(ou); alloc_rot_i = 7'(ro);
        @(negedge clk);
        call_i = 0; ret_i = 0; alloc_i = 0; rotate_i = 0;
        exp_err = model_ev(c, r, a, lo, ou, ro, rt);
        chk(err_o == 1'(exp_err), req, err_o, exp_err);
        chk(wrap_o == ((m_base + m_loc + m_out) > 96), "R9", wrap_o,
            (m_base + m_loc + m_out) > 96);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int p0, p1, p2, p3;
        bit o;
        void'($urandom(32'h5eed_1234));
        m_base = 0; m_loc = 0; m_out = 0; m_rot = 0; m_rrb = 0; sp = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        chk(err_o == 1'b0, "R11", err_o, 0);
        chk(wrap_o == 1'b0, "R11", wrap_o, 0);
        check_map(32, "R11");
        check_map(5, "R1");
        check_map(31, "R1");

        // R5 accepted allocate and R2/R6 mapping
        ev(0, 0, 1, 8, 4, 8, 0, "R5");
        for (int l = 30; l < 46; l++) check_map(l, "R2");

        // R7 rotation shifts toward higher numbers
        read_map(33, p0, o); read_map(39, p1, o);
        ev(0, 0, 0, 0, 0, 0, 1, "R7");
        read_map(34, p2, o); read_map(32, p3, o);
        chk(p2 == p0, "R7", p2, p0);
        chk(p3 == p1, "R7", p3, p1);
        ev(0, 0, 0, 0, 0, 0, 1, "R7");
        ev(0, 0, 0, 0, 0, 0, 1, "R7");
        for (int l = 32; l < 44; l++) check_map(l, "R6");

        // R5 rejected allocates keep old mapping
        ev(0, 0, 1, 8, 4, 4, 0, "R5");
        ev(0, 0, 1, 8, 4, 16, 0, "R5");
        ev(0, 0, 1, 90, 10, 0, 0, "R5");
        for (int l = 32; l < 44; l++) check_map(l, "R5");

        // R3 call overlays output area
        read_map(32 + 8, p0, o);
        ev(1, 0, 0, 0, 0, 0, 0, "R3");
        read_map(32, p1, o);
        chk(p1 == p0, "R3", p1, p0);
        check_map(35, "R3");
        check_map(36, "R3");

        // R4 return restores, then empty return rejected
        ev(0, 1, 0, 0, 0, 0, 0, "R4");
        for (int l = 32; l < 44; l++) check_map(l, "R4");
        ev(0, 1, 0, 0, 0, 0, 0, "R4");
        check_map(33, "R4");

        // R8 depth limit
        for (int k = 0; k < 8; k++) begin
            ev(0, 0, 1, 5, 3, 0, 0, "R8");
            ev(1, 0, 0, 0, 0, 0, 0, "R8");
        end
        ev(1, 0, 0, 0, 0, 0, 0, "R8");
        check_map(33, "R8");
        for (int k = 0; k < 8; k++) ev(0, 1, 0, 0, 0, 0, 0, "R8");
        ev(0, 1, 0, 0, 0, 0, 0, "R4");

        // R9 frame straddling end of pool
        ev(0, 0, 1, 90, 6, 0, 0, "R9");
        ev(1, 0, 0, 0, 0, 0, 0, "R9");
        ev(0, 0, 1, 10, 0, 8, 0, "R9");
        check_map(39, "R9");
        check_map(32, "R9");
        ev(0, 1, 0, 0, 0, 0, 0, "R9");

        // R10 priority
        ev(0, 0, 1, 8, 8, 8, 0, "R10");
        ev(1, 1, 1, 16, 0, 8, 1, "R10");
        check_map(32, "R10");
        check_map(39, "R10");
        ev(0, 0, 1, 8, 8, 8, 0, "R10");
        ev(0, 1, 1, 4, 4, 0, 1, "R10");
        for (int l = 32; l < 50; l++) check_map(l, "R10");
        ev(0, 0, 1, 16, 0, 8, 1, "R10");
        check_map(33, "R10");

        // random mix
        for (int it = 0; it < 1500; it++) begin
            int k, lo, ou, ro;
            bit c, r, a, rt;
            k = $urandom % 10;
            c = (k < 2); r = (k == 2 || k == 3); a = (k == 4 || k == 5);
            rt = (k >= 6 && k <= 8) || ($urandom % 8 == 0);
            lo = $urandom % 50; ou = $urandom % 24;
            ro = ($urandom % 5 == 0) ? ($urandom % 64) : (($urandom % 6) * 8);
            ev(c, r, a, lo, ou, ro, rt, "R11");
            check_map(32, "R6");
            check_map(32 + ($urandom % 96), "R2");
            check_map($urandom % 128, "R2");
            if (m_loc + m_out > 0) check_map(32 + m_loc + m_out - 1, "R2");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule